// File: doc/BRIEF.md
# Downstream Bus Hazard Monitor

This block watches the two wires of a downstream I2C bus, clock and data, and works out whether a transfer is in progress. A START condition marks the bus busy. A STOP condition marks it idle again. The bus also returns to idle when both lines have stayed high for a programmable number of cycles with no STOP, which covers a master that vanished in mid-transfer. Both wires enter through two-flop synchronizers before any edge is examined, so they may be driven asynchronously.

When the surrounding selector switches the downstream channel to another upstream master, it pulses a switch strobe. The block latches an interrupt request if all of the following hold on that strobe: the bus was busy, the internal recovery sequence is disabled, and the interrupt is not masked. The request tells the new master that it must run its own bus recovery. The request stays high until it is cleared.

The bus tracker is a two-state machine with states `BUS_IDLE` and `BUS_BUSY`, and it has three transitions:
- `start_seen` moves `BUS_IDLE` to `BUS_BUSY`.
- `stop_seen` moves `BUS_BUSY` to `BUS_IDLE`.
- `idle_timeout` moves `BUS_BUSY` to `BUS_IDLE`.

The interrupt latch is a two-state machine with states `IRQ_QUIET` and `IRQ_RAISED`, and it has two transitions:
- `hazard_hit` moves `IRQ_QUIET` to `IRQ_RAISED`.
- `clear_ack` moves `IRQ_RAISED` to `IRQ_QUIET`.

Top module: `bus_hazard_monitor`

## Requirements
- R1: After reset is asserted, `bus_busy` and `hazard_irq` are both 0.
- R2: A START is SDA falling while SCL stays high. It sets `bus_busy` exactly 3 clock edges after the input change: 2 synchronizer stages and 1 state register.
- R3: A STOP is SDA rising while SCL stays high. It clears `bus_busy` exactly 3 clock edges after the input change.
- R4: SDA changes made while SCL is low do not change `bus_busy`, whether the bus is idle or busy.
- R5: In `BUS_BUSY`, `bus_busy` clears when the synchronized SCL and SDA have both been high for `IDLE_TO` consecutive cycles. It clears on the `IDLE_TO`+2-th edge after the last line rises, and it is still set one edge earlier.
- R6: A `switch_evt` pulse sets `hazard_irq` on the same edge that samples the pulse, provided that on that cycle `bus_busy` is 1, `recov_en` is 0 and `irq_mask` is 0.
- R7: A `switch_evt` pulse while `bus_busy` is 0 does not raise `hazard_irq`.
- R8: A `switch_evt` pulse while `recov_en` is 1 does not raise `hazard_irq`.
- R9: A `switch_evt` pulse while `irq_mask` is 1 does not raise `hazard_irq`.
- R10: Once set, `hazard_irq` stays 1 until `irq_clr` is sampled high. It is 0 after that edge.
- R11: If `irq_clr` and a qualifying switch hazard are sampled on the same edge, `hazard_irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Downstream clock line, asynchronous |
| sda_in | input | 1 | Downstream data line, asynchronous |
| switch_evt | input | 1 | One-cycle strobe: the channel was switched |
| recov_en | input | 1 | 1 when the internal recovery sequence is in use |
| irq_mask | input | 1 | 1 suppresses the hazard interrupt |
| irq_clr | input | 1 | Clears a latched hazard interrupt |
| bus_busy | output | 1 | 1 while a transfer is judged in progress |
| hazard_irq | output | 1 | Latched request for the new master to recover the bus |

## Verification
Each bus-line change reaches `bus_busy` on the third clock edge after it. The bench therefore samples one edge before that and on that edge, to pin the latency exactly. The timeout is checked at `IDLE_TO`+1 and `IDLE_TO`+2 edges after the last line rises. A switch strobe or a clear shows on `hazard_irq` one edge after it is driven. The driver pushes every expectation immediately after the edge on which the result is due. The monitor compares it later in the same cycle, once the registered outputs have settled.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[gi]};
                end
            end
            assign sync_out[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cond_detect.sv
module cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_seen,
    output logic stop_seen,
    output logic lines_high
);

    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        start_seen = scl_prev & scl_s & sda_prev & ~sda_s;
        stop_seen  = scl_prev & scl_s & ~sda_prev & sda_s;
        lines_high = scl_s & sda_s;
    end

endmodule

// File: rtl/bus_state_fsm.sv
module bus_state_fsm
    import bhm_pkg::*;
#(
    parameter int IDLE_TO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_seen,
    input  logic stop_seen,
    input  logic lines_high,
    output logic busy
);

    localparam int CNT_W = $clog2(IDLE_TO + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_TO - 1);

    bus_state_t state_q, state_d;
    logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
    logic idle_timeout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= BUS_IDLE;
            hi_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            hi_cnt_q <= hi_cnt_d;
        end
    end

    always_comb begin
        idle_timeout = (state_q == BUS_BUSY) && lines_high && (hi_cnt_q == CNT_LAST);
        state_d  = state_q;
        hi_cnt_d = '0;
        unique case (state_q)
            BUS_IDLE: begin
                if (start_seen) state_d = BUS_BUSY;
            end
            BUS_BUSY: begin
                if (stop_seen) begin
                    state_d = BUS_IDLE;
                end else if (idle_timeout) begin
                    state_d = BUS_IDLE;
                end else if (lines_high) begin
                    hi_cnt_d = hi_cnt_q + 1'b1;
                end
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == BUS_BUSY);
    end

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> busy);

    // R3
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q < CNT_W'(IDLE_TO));

    // R4
    no_spurious_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_seen) |=> !busy);

endmodule

// File: rtl/irq_latch.sv
module irq_latch
    import bhm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic switch_evt,
    input  logic busy,
    input  logic recov_en,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic irq
);

    irq_state_t state_q, state_d;
    logic hazard_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        hazard_hit = switch_evt & busy & ~recov_en & ~irq_mask;
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (hazard_hit) state_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (irq_clr && !hazard_hit) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    // R6
    hazard_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_evt && busy && !recov_en && !irq_mask) |=> irq);

    // R8
    recov_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && switch_evt && recov_en) |=> !irq);

    // R9
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && switch_evt && irq_mask) |=> !irq);

    // R10
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr && !switch_evt) |=> !irq);

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/bus_hazard_monitor.sv
module bus_hazard_monitor #(
    parameter int IDLE_TO     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic switch_evt,
    input  logic recov_en,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic bus_busy,
    output logic hazard_irq
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_sync;
    logic start_seen;
    logic stop_seen;
    logic lines_high;

    line_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_sync)
    );

    cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_sync[1]),
        .sda_s      (lines_sync[0]),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .lines_high (lines_high)
    );

    bus_state_fsm #(
        .IDLE_TO (IDLE_TO)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .lines_high (lines_high),
        .busy       (bus_busy)
    );

    irq_latch u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .switch_evt (switch_evt),
        .busy       (bus_busy),
        .recov_en   (recov_en),
        .irq_mask   (irq_mask),
        .irq_clr    (irq_clr),
        .irq        (hazard_irq)
    );

    // R7
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hazard_irq && !bus_busy) |=> !hazard_irq);

endmodule

// File: tb/bus_hazard_monitor_tb.sv
module bus_hazard_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_IDLE_TO = 20;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic switch_evt = 1'b0;
    logic recov_en = 1'b0;
    logic irq_mask = 1'b0;
    logic irq_clr = 1'b0;
    logic bus_busy;
    logic hazard_irq;

    typedef struct {
        string tag;
        logic  exp_busy;
        logic  exp_irq;
    } exp_item_t;

    exp_item_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic exp_busy = 1'b0;
    logic exp_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hazard_monitor #(
        .IDLE_TO     (TB_IDLE_TO),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .switch_evt (switch_evt),
        .recov_en   (recov_en),
        .irq_mask   (irq_mask),
        .irq_clr    (irq_clr),
        .bus_busy   (bus_busy),
        .hazard_irq (hazard_irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input string tag);
        exp_item_t it;
        it.tag = tag;
        it.exp_busy = exp_busy;
        it.exp_irq = exp_irq;
        exp_q.push_back(it);
    endtask

    task automatic strobe_switch();
        switch_evt = 1'b1;
        tick(1);
        switch_evt = 1'b0;
    endtask

    initial begin : monitor
        exp_item_t it;
        forever begin
            @(posedge clk);
            #4;
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                total++;
                if (bus_busy !== it.exp_busy || hazard_irq !== it.exp_irq) begin
                    bad++;
                    $display("FAIL %s: busy=%b irq=%b expected busy=%b irq=%b",
                             it.tag, bus_busy, hazard_irq, it.exp_busy, it.exp_irq);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        rst_n = 1'b1;
        tick(1);
        push("R1 reset state");

        // R7: switch on idle bus
        strobe_switch();
        push("R7 idle switch");

        // R2: START
        sda_in = 1'b0;
        tick(2);
        push("R2 before latency");
        tick(1);
        exp_busy = 1'b1;
        push("R2 start sets busy");

        // R4: data changes with clock low
        scl_in = 1'b0;
        tick(1);
        sda_in = 1'b1;
        tick(1);
        sda_in = 1'b0;
        tick(1);
        scl_in = 1'b1;
        tick(4);
        push("R4 busy held through data bits");

        // R6: hazard
        strobe_switch();
        exp_irq = 1'b1;
        push("R6 switch on busy bus");
        tick(5);
        push("R10 irq held");

        // R3: STOP
        sda_in = 1'b1;
        tick(2);
        push("R3 before latency");
        tick(1);
        exp_busy = 1'b0;
        push("R3 stop clears busy");

        // R10: clear
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        exp_irq = 1'b0;
        push("R10 clear");

        // R4: data changes with clock low on idle bus
        scl_in = 1'b0;
        tick(1);
        sda_in = 1'b0;
        tick(1);
        sda_in = 1'b1;
        tick(1);
        scl_in = 1'b1;
        tick(4);
        push("R4 idle held through data bits");

        // new START
        sda_in = 1'b0;
        tick(3);
        exp_busy = 1'b1;
        push("R2 second start");

        // R9: masked
        irq_mask = 1'b1;
        strobe_switch();
        irq_mask = 1'b0;
        push("R9 mask blocks irq");

        // R8: recovery enabled
        recov_en = 1'b1;
        strobe_switch();
        recov_en = 1'b0;
        push("R8 recovery blocks irq");

        // R11: clear and hazard together
        strobe_switch();
        exp_irq = 1'b1;
        push("R6 second hazard");
        switch_evt = 1'b1;
        irq_clr = 1'b1;
        tick(1);
        switch_evt = 1'b0;
        irq_clr = 1'b0;
        push("R11 set wins over clear");
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        exp_irq = 1'b0;
        push("R10 clear after tie");

        // R5: timeout with lines high and no STOP
        scl_in = 1'b0;
        tick(1);
        sda_in = 1'b1;
        tick(1);
        scl_in = 1'b1;
        tick(TB_IDLE_TO + 1);
        push("R5 still busy before timeout");
        tick(1);
        exp_busy = 1'b0;
        push("R5 timeout clears busy");

        strobe_switch();
        push("R7 switch after timeout");

        tick(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule